// File: doc/BRIEF.md
# Prioritized Interrupt Arbiter with Vector Address Generation

This block selects one interrupt request from a set of request nodes. Each node has a request flag, an enable and a programmable priority number. Hardware lines set a flag. Software can set or clear any flag with strobes. Every cycle the block picks the enabled, flagged node with the highest priority number and registers that number as the pending priority. A priority number of zero stands for "nothing pending".

A pending request is taken only when the global interrupt enable is on and its priority is strictly above the current CPU priority. Because the comparison is strict, software can build priority groups by raising the CPU priority inside a handler. When a request is taken, the block does the following on the same clock edge:

- It issues a one-cycle take pulse.
- It forms the handler fetch address from a base register and the priority number.
- It raises the CPU priority to the accepted level.
- It clears the global enable.
- It keeps the previous priority and enable in a one-level save slot. A return-from-exception strobe puts them back.

Top module: `irq_vec_arbiter`

## Requirements
- R1: `pend_prio` is loaded every cycle with the highest priority number among nodes whose flag and enable are both 1, or with 0 when there is none; it is visible the cycle after the flags. A node programmed with priority 0 is never pending.
- R2: When several candidate nodes share the highest priority number, the node with the lowest index wins.
- R3: A request is taken only when `glob_en` is 1 and the winning priority is strictly greater than `cpu_prio`; a taken request shows as `take` high for exactly one cycle, registered one edge after the arbitration.
- R4: On the edge that raises `take`, `cpu_prio` becomes the accepted priority, `glob_en` becomes 0, the old values go into the save slot, and the winner's flag is cleared, unless a set strobe for that node arrives on the same edge (set wins over any clear).
- R5: A `rfe` pulse restores `cpu_prio` and `glob_en` from the save slot on the next edge.
- R6: `vec_addr` = `base_addr` | (accepted priority << 5), captured on the take edge, giving entries 32 bytes apart.
- R7: `base_addr` resets to `BASE_RST` (default 0x0000_2000). A `base_wr` loads `base_wdata` with bit 0 forced to 0.
- R8: `hw_req[i]` sets flag i only for nodes marked in `HW_MASK` (default 0x0F, nodes 0 to 3); other nodes ignore it. `sw_set` sets any flag and `sw_clr` clears any flag.
- R9: A node whose `node_en` bit is 0 is not a candidate, and its flag stays set.
- R10: `ctx_wr` loads `cpu_prio` and `glob_en` from `ctx_prio`/`ctx_ie`. In a cycle with `rfe` or `ctx_wr` no request is taken, and `rfe` has priority over `ctx_wr`.
- R11: After reset, flags, `pend_prio`, `cpu_prio`, `glob_en`, `take` and `vec_addr` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_req | input | N_NODE | Hardware request pulses |
| sw_set | input | N_NODE | Software flag set strobes |
| sw_clr | input | N_NODE | Software flag clear strobes |
| node_en | input | N_NODE | Per-node enable |
| node_prio | input | N_NODE*8 | Per-node priority number, node i in bits [8i+7:8i] |
| ctx_wr | input | 1 | Write CPU priority and global enable |
| ctx_ie | input | 1 | Global enable value for ctx_wr |
| ctx_prio | input | 8 | CPU priority value for ctx_wr |
| rfe | input | 1 | Return-from-exception strobe |
| base_wr | input | 1 | Vector base write strobe |
| base_wdata | input | ADDR_W | Vector base write data |
| take | output | 1 | Interrupt taken pulse |
| vec_addr | output | ADDR_W | Handler fetch address |
| pend_prio | output | 8 | Pending priority number |
| cpu_prio | output | 8 | Current CPU priority |
| glob_en | output | 1 | Global interrupt enable |
| base_addr | output | ADDR_W | Vector base register |
| req_flags | output | N_NODE | Request flags |

## Verification
The bench covers several boundary cases and the failure each one would expose:
- **Equal priority.** A winner equal to the CPU priority must not be taken. An off-by-one (`>=`) compare would fire a nested interrupt inside its own group.
- **Tie between two nodes.** An arbiter that lets later nodes win would clear the wrong flag, and the remaining flag pattern shows this.
- **Zero-priority and disabled nodes.** Either one would wrongly appear as pending.
- **Hardware line on a software-only node.** A node without a hardware source must not set its flag.
- **Base register bit 0.** Writing 1 to bit 0 must read back as 0.
- **Vector with a moved base.** A wrong shift shows up directly in the vector address.
- **Return-from-exception.** A missing save slot would leave the CPU priority raised and interrupts disabled.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned PRIO_W    = 8;
  localparam int unsigned VEC_SHIFT = 5;

  typedef logic [PRIO_W-1:0] prio_t;

  typedef struct packed {
    logic  ie;
    prio_t prio;
  } cpu_ctx_t;
endpackage

// File: rtl/irq_node_flags.sv
module irq_node_flags #(
  parameter int unsigned N_NODE  = 8,
  parameter logic [N_NODE-1:0] HW_MASK = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_NODE-1:0] hw_req,
  input  logic [N_NODE-1:0] sw_set,
  input  logic [N_NODE-1:0] sw_clr,
  input  logic [N_NODE-1:0] take_clr,
  output logic [N_NODE-1:0] flags
);
  logic [N_NODE-1:0] flag_q, flag_n, set_v;

  // hardware lines only reach nodes that have a source
  assign set_v  = (hw_req & HW_MASK) | sw_set;
  assign flag_n = (flag_q & ~(sw_clr | take_clr)) | set_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= flag_n;
  end

  assign flags = flag_q;

  for (genvar g = 0; g < N_NODE; g++) begin : g_chk
    assert_take_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (take_clr[g] && !set_v[g]) |=> !flag_q[g]);
    if (!HW_MASK[g]) begin : g_sw_only
      assert_hw_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_q[g] && !sw_set[g]) |=> !flag_q[g]);
    end
  end
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick
  import irq_pkg::*;
#(
  parameter int unsigned N_NODE = 8,
  localparam int unsigned IDX_W = (N_NODE > 1) ? $clog2(N_NODE) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [N_NODE-1:0]        flags,
  input  logic [N_NODE-1:0]        node_en,
  input  logic [N_NODE*PRIO_W-1:0] node_prio,
  output logic                     win_valid,
  output logic [IDX_W-1:0]         win_idx,
  output prio_t                    win_prio
);
  always_comb begin
    win_prio = '0;
    win_idx  = '0;
    for (int i = 0; i < N_NODE; i++) begin
      // strict compare keeps the lowest index on a tie; prio 0 never wins
      if (flags[i] && node_en[i] && (node_prio[i*PRIO_W +: PRIO_W] > win_prio)) begin
        win_prio = node_prio[i*PRIO_W +: PRIO_W];
        win_idx  = IDX_W'(i);
      end
    end
  end

  assign win_valid = (win_prio != '0);

  assert_win_is_candidate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> (flags[win_idx] && node_en[win_idx]));
endmodule

// File: rtl/irq_accept_ctrl.sv
module irq_accept_ctrl
  import irq_pkg::*;
#(
  parameter int unsigned ADDR_W   = 32,
  parameter logic [ADDR_W-1:0] BASE_RST = 32'h0000_2000,
  localparam int unsigned PAD_W = ADDR_W - PRIO_W - VEC_SHIFT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              win_valid,
  input  prio_t             win_prio,
  input  logic              ctx_wr,
  input  cpu_ctx_t          ctx_wdata,
  input  logic              rfe,
  input  logic              base_wr,
  input  logic [ADDR_W-1:0] base_wdata,
  output logic              accept,
  output logic              take_o,
  output logic [ADDR_W-1:0] vec_o,
  output prio_t             pend_o,
  output cpu_ctx_t          cpu_o,
  output logic [ADDR_W-1:0] base_o
);
  cpu_ctx_t          cur_q, cur_n, sv_q, sv_n;
  logic              take_q, take_n;
  logic [ADDR_W-1:0] vec_q, vec_n, base_q, base_n;
  prio_t             pend_q, pend_n;

  always_comb begin
    accept = win_valid && cur_q.ie && (win_prio > cur_q.prio) && !rfe && !ctx_wr;
    cur_n  = cur_q;
    sv_n   = sv_q;
    vec_n  = vec_q;
    take_n = accept;
    pend_n = win_prio;
    base_n = base_wr ? (base_wdata & ~ADDR_W'(1)) : base_q;
    if (rfe) begin
      cur_n = sv_q;
    end else if (ctx_wr) begin
      cur_n = ctx_wdata;
    end else if (accept) begin
      sv_n       = cur_q;
      cur_n.ie   = 1'b0;
      cur_n.prio = win_prio;
      vec_n      = base_q | {{PAD_W{1'b0}}, win_prio, {VEC_SHIFT{1'b0}}};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q  <= '0;
      sv_q   <= '0;
      take_q <= 1'b0;
      vec_q  <= '0;
      pend_q <= '0;
      base_q <= BASE_RST & ~ADDR_W'(1);
    end else begin
      cur_q  <= cur_n;
      sv_q   <= sv_n;
      take_q <= take_n;
      vec_q  <= vec_n;
      pend_q <= pend_n;
      base_q <= base_n;
    end
  end

  assign take_o = take_q;
  assign vec_o  = vec_q;
  assign pend_o = pend_q;
  assign cpu_o  = cur_q;
  assign base_o = base_q;

  assert_take_strict_R3: assert property (@(posedge clk) disable iff (!rst_n)
    take_q |-> (sv_q.ie && (pend_q > sv_q.prio)));
  assert_take_raises_R4: assert property (@(posedge clk) disable iff (!rst_n)
    take_q |-> (!cur_q.ie && (cur_q.prio == pend_q)));
  assert_rfe_restore_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rfe |=> (cur_q == $past(sv_q)));
  assert_base_lsb_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !base_q[0]);
endmodule

// File: rtl/irq_vec_arbiter.sv
module irq_vec_arbiter
  import irq_pkg::*;
#(
  parameter int unsigned N_NODE = 8,
  parameter int unsigned ADDR_W = 32,
  parameter logic [ADDR_W-1:0] BASE_RST = 32'h0000_2000,
  parameter logic [N_NODE-1:0] HW_MASK  = 8'h0F,
  localparam int unsigned IDX_W = (N_NODE > 1) ? $clog2(N_NODE) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [N_NODE-1:0]        hw_req,
  input  logic [N_NODE-1:0]        sw_set,
  input  logic [N_NODE-1:0]        sw_clr,
  input  logic [N_NODE-1:0]        node_en,
  input  logic [N_NODE*PRIO_W-1:0] node_prio,
  input  logic                     ctx_wr,
  input  logic                     ctx_ie,
  input  logic [PRIO_W-1:0]        ctx_prio,
  input  logic                     rfe,
  input  logic                     base_wr,
  input  logic [ADDR_W-1:0]        base_wdata,
  output logic                     take,
  output logic [ADDR_W-1:0]        vec_addr,
  output logic [PRIO_W-1:0]        pend_prio,
  output logic [PRIO_W-1:0]        cpu_prio,
  output logic                     glob_en,
  output logic [ADDR_W-1:0]        base_addr,
  output logic [N_NODE-1:0]        req_flags
);
  logic [N_NODE-1:0] flags, take_clr;
  logic              win_valid, accept;
  logic [IDX_W-1:0]  win_idx;
  prio_t             win_prio;
  cpu_ctx_t          ctx_w, cpu_ctx;

  assign ctx_w = '{ie: ctx_ie, prio: ctx_prio};

  for (genvar g = 0; g < N_NODE; g++) begin : g_clr
    assign take_clr[g] = accept && (win_idx == IDX_W'(g));
  end

  irq_node_flags #(.N_NODE(N_NODE), .HW_MASK(HW_MASK)) u_flags (
    .clk(clk), .rst_n(rst_n), .hw_req(hw_req), .sw_set(sw_set),
    .sw_clr(sw_clr), .take_clr(take_clr), .flags(flags)
  );

  irq_prio_pick #(.N_NODE(N_NODE)) u_pick (
    .clk(clk), .rst_n(rst_n), .flags(flags), .node_en(node_en),
    .node_prio(node_prio), .win_valid(win_valid), .win_idx(win_idx),
    .win_prio(win_prio)
  );

  irq_accept_ctrl #(.ADDR_W(ADDR_W), .BASE_RST(BASE_RST)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .win_valid(win_valid), .win_prio(win_prio),
    .ctx_wr(ctx_wr), .ctx_wdata(ctx_w), .rfe(rfe), .base_wr(base_wr),
    .base_wdata(base_wdata), .accept(accept), .take_o(take),
    .vec_o(vec_addr), .pend_o(pend_prio), .cpu_o(cpu_ctx), .base_o(base_addr)
  );

  assign cpu_prio  = cpu_ctx.prio;
  assign glob_en   = cpu_ctx.ie;
  assign req_flags = flags;

  assert_take_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(take_clr));
endmodule

// File: tb/tb_irq_vec_arbiter.sv
`timescale 1ns/1ps
module tb_irq_vec_arbiter;
  localparam int N = 8;
  localparam logic [31:0] BASE0 = 32'h0000_2000;

  logic clk = 1'b0;
  logic rst_n;
  logic [N-1:0] hw_req, sw_set, sw_clr, node_en;
  logic [N*8-1:0] node_prio;
  logic ctx_wr, ctx_ie, rfe, base_wr;
  logic [7:0] ctx_prio;
  logic [31:0] base_wdata;
  logic take, glob_en;
  logic [31:0] vec_addr, base_addr;
  logic [7:0] pend_prio, cpu_prio;
  logic [N-1:0] req_flags;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  irq_vec_arbiter dut (
    .clk(clk), .rst_n(rst_n), .hw_req(hw_req), .sw_set(sw_set), .sw_clr(sw_clr),
    .node_en(node_en), .node_prio(node_prio), .ctx_wr(ctx_wr), .ctx_ie(ctx_ie),
    .ctx_prio(ctx_prio), .rfe(rfe), .base_wr(base_wr), .base_wdata(base_wdata),
    .take(take), .vec_addr(vec_addr), .pend_prio(pend_prio), .cpu_prio(cpu_prio),
    .glob_en(glob_en), .base_addr(base_addr), .req_flags(req_flags)
  );

  // node priorities: 0:10 1:20 2:30 3:30 4:5 5:200 6:0 7:255
  assign node_prio = {8'd255, 8'd0, 8'd200, 8'd5, 8'd30, 8'd30, 8'd20, 8'd10};

  typedef struct packed {
    logic [7:0] set;
    logic [7:0] cpu;
    logic       ie;
    logic       tk;
    logic [7:0] pp;
    logic [7:0] fl;
  } vec_t;

  localparam vec_t TBL [10] = '{
    '{8'h01, 8'd0,   1'b1, 1'b1, 8'd10,  8'h00},  // R1 R3 single
    '{8'h03, 8'd0,   1'b1, 1'b1, 8'd20,  8'h01},  // R1 highest wins
    '{8'h0C, 8'd0,   1'b1, 1'b1, 8'd30,  8'h08},  // R2 tie, node 2 wins
    '{8'h0C, 8'd30,  1'b1, 1'b0, 8'd30,  8'h0C},  // R3 equal not taken
    '{8'h01, 8'd10,  1'b1, 1'b0, 8'd10,  8'h01},  // R3 equal not taken
    '{8'h02, 8'd10,  1'b1, 1'b1, 8'd20,  8'h00},  // R3 above
    '{8'hFF, 8'd0,   1'b0, 1'b0, 8'd255, 8'hFF},  // R3 enable off
    '{8'h40, 8'd0,   1'b1, 1'b0, 8'd0,   8'h40},  // R1 prio 0 never pending
    '{8'h90, 8'd100, 1'b1, 1'b1, 8'd255, 8'h10},  // R4 top node
    '{8'h30, 8'd199, 1'b1, 1'b1, 8'd200, 8'h10}   // R4 just above
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle();
    hw_req = '0; sw_set = '0; sw_clr = '0; ctx_wr = 0; rfe = 0; base_wr = 0;
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  // clear flags and load CPU context, then post a set mask, then arbitrate
  task automatic run(input logic [7:0] set, input logic [7:0] cpu, input logic ie);
    idle(); sw_clr = '1; ctx_wr = 1; ctx_prio = cpu; ctx_ie = ie;
    step();
    idle(); sw_set = set;
    step();
    idle();
    step();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 0; idle(); ctx_ie = 0; ctx_prio = 0; base_wdata = '0; node_en = '1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11 reset state, R7 base reset
    chk("R11 take", 32'(take), 0);
    chk("R11 pend", 32'(pend_prio), 0);
    chk("R11 cpu", 32'(cpu_prio), 0);
    chk("R11 ie", 32'(glob_en), 0);
    chk("R11 flags", 32'(req_flags), 0);
    chk("R11 vec", vec_addr, 0);
    chk("R7 base reset", base_addr, BASE0);

    for (int k = 0; k < 10; k++) begin
      run(TBL[k].set, TBL[k].cpu, TBL[k].ie);
      chk($sformatf("R3 take v%0d", k), 32'(take), 32'(TBL[k].tk));
      chk($sformatf("R1 pend v%0d", k), 32'(pend_prio), 32'(TBL[k].pp));
      chk($sformatf("R4 flags v%0d", k), 32'(req_flags), 32'(TBL[k].fl));
      if (TBL[k].tk) begin
        chk($sformatf("R6 vec v%0d", k), vec_addr, BASE0 | (32'(TBL[k].pp) << 5));
        chk($sformatf("R4 cpu v%0d", k), 32'(cpu_prio), 32'(TBL[k].pp));
        chk($sformatf("R4 ie v%0d", k), 32'(glob_en), 0);
        step();
        chk($sformatf("R3 pulse v%0d", k), 32'(take), 0);
      end else begin
        chk($sformatf("R10 cpu v%0d", k), 32'(cpu_prio), 32'(TBL[k].cpu));
      end
    end

    // R7 base write drops bit 0; R6 vector follows new base
    idle(); base_wr = 1; base_wdata = 32'h0001_4001;
    step(); idle();
    chk("R7 base bit0", base_addr, 32'h0001_4000);
    run(8'h02, 8'd0, 1'b1);
    chk("R6 vec new base", vec_addr, 32'h0001_4280);

    // R5 return restores the saved context
    run(8'h01, 8'd7, 1'b1);
    chk("R4 cpu raised", 32'(cpu_prio), 10);
    idle(); rfe = 1;
    step(); idle();
    chk("R5 cpu restored", 32'(cpu_prio), 7);
    chk("R5 ie restored", 32'(glob_en), 1);
    chk("R5 no retake", 32'(take), 0);

    // R8 hardware line ignored on software-only node
    idle(); sw_clr = '1; ctx_wr = 1; ctx_ie = 0; ctx_prio = 0;
    step(); idle(); hw_req = 8'h24;
    step(); idle();
    step();
    chk("R8 hw flags", 32'(req_flags), 32'h04);
    chk("R1 hw pend", 32'(pend_prio), 30);
    idle(); sw_clr = 8'h04;
    step(); idle();
    chk("R8 sw clear", 32'(req_flags), 0);

    // R9 disabled node is not a candidate
    node_en = 8'h7F;
    run(8'h80, 8'd0, 1'b1);
    chk("R9 no take", 32'(take), 0);
    chk("R9 pend", 32'(pend_prio), 0);
    chk("R9 flag kept", 32'(req_flags), 32'h80);
    node_en = '1;

    // R10 ctx_wr cycle blocks acceptance
    idle(); sw_clr = '1; ctx_wr = 1; ctx_ie = 1; ctx_prio = 0;
    step(); idle(); sw_set = 8'h01; step();
    idle(); ctx_wr = 1; ctx_ie = 1; ctx_prio = 0;
    step(); idle();
    chk("R10 blocked", 32'(take), 0);
    step();
    chk("R10 after", 32'(take), 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule